// File: doc/BRIEF.md
# Selectable-Position Rounding Stage

This block sits at the end of a fixed-point filter datapath. It takes the 28-bit accumulated sum once per sample and rounds it by adding a single one at a bit position that a 4-bit code chooses. It registers the result for one cycle and reports how many of the most significant bits are meaningful, both as a count and as a bit mask. The binary point of the sum lies between bit 18 and bit 17. Bit 27 weighs 2^9, bit 18 weighs 2^0 and bit 0 weighs 2^-18. The rounding one can land anywhere from weight 2^1 (bit 19) down to weight 2^-10 (bit 8).

The bits below the rounding point are not cleared. Downstream logic uses the mask to ignore them. Three mode flags describe the filter configuration: even-symmetric operation, unsigned data and unsigned coefficients. From these the stage derives whether the result is to be read as unsigned or as two's complement. The code and the flags are captured with the sum they belong to, so each sample can use its own rounding point.

Top module: `round_stage`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_word, out_mask, out_width and out_signed are all zero.
- R2: out_valid equals in_valid delayed by one clock. When in_valid is low, out_word, out_mask, out_width and out_signed keep their previous values.
- R3: For a code n in 0..11, out_word is (in_sum + 2^(19-n)) mod 2^28 one cycle after the sample. Code 0 adds at bit 19 and code 11 adds at bit 8.
- R4: For a code n in 0..11, out_width is 8+n and out_mask has ones in exactly its top 8+n bits (bits 27 down to 20-n).
- R5: Codes 12..15 add nothing. out_word equals in_sum, out_width is 28 and out_mask is all ones.
- R6: A carry out of bit 27 is dropped. For example, 0xFFFFFFF with code 0 gives 0x007FFFF.
- R7: out_signed is 0 (unsigned result) only when in_even_sym, in_data_uns and in_coef_uns are all 1. Otherwise it is 1 (two's complement).
- R8: Code and flags are taken from the same edge as in_sum. Back-to-back samples with different codes are each rounded by their own code.
- R9: Rounding to ten MSBs uses code 2, which adds at bit 17 (weight 2^-1) and reports out_width 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sum | input | 28 | Accumulated sum, binary point after bit 18 |
| in_code | input | 4 | Rounding position code |
| in_even_sym | input | 1 | Filter runs even-symmetric |
| in_data_uns | input | 1 | Data samples are unsigned |
| in_coef_uns | input | 1 | Coefficients are unsigned |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 28 | Rounded, untruncated word |
| out_mask | output | 28 | Ones over the meaningful MSBs |
| out_width | output | 5 | Number of meaningful MSBs |
| out_signed | output | 1 | 1 when the result is two's complement |

## Verification
The hardest case to reach is a carry that runs out of bit 27 and must vanish. It only occurs when every bit from the rounding point upward is already one, so the stimulus applies an all-ones sum with the highest rounding position. A second hard case is a code change between adjacent samples, where a stage that captured the code late would round a sample by its neighbour's position. The bench drives consecutive samples with different codes and no idle cycle between them. It checks each result as it arrives.

// File: rtl/round_pkg.sv
package round_pkg;
    localparam int OUT_W     = 28;
    localparam int CODE_W    = 4;
    localparam int NUM_POS   = 12;
    localparam int TOP_POS   = 19;
    localparam int BASE_BITS = 8;
    localparam int WID_W     = $clog2(OUT_W + 1);

    typedef logic [OUT_W-1:0] word_t;

    typedef struct packed {
        logic              valid;
        word_t             word;
        word_t             mask;
        logic [WID_W-1:0]  width;
        logic              is_signed;
    } rnd_out_t;

    // unsigned result only for even-symmetric with unsigned data and coefficients
    function automatic logic result_signed(input logic even_sym, input logic data_uns,
                                           input logic coef_uns);
        return !(even_sym && data_uns && coef_uns);
    endfunction
endpackage

// File: rtl/round_decode.sv
module round_decode #(
    parameter int OUT_W     = round_pkg::OUT_W,
    parameter int CODE_W    = round_pkg::CODE_W,
    parameter int NUM_POS   = round_pkg::NUM_POS,
    parameter int TOP_POS   = round_pkg::TOP_POS,
    parameter int BASE_BITS = round_pkg::BASE_BITS,
    parameter int WID_W     = round_pkg::WID_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  addend,
    output logic [OUT_W-1:0]  mask,
    output logic [WID_W-1:0]  width
);
    localparam int LOW_POS = TOP_POS - NUM_POS + 1;

    logic reserved;
    assign reserved = ({1'b0, code} >= (CODE_W+1)'(NUM_POS));
    assign width    = reserved ? WID_W'(OUT_W) : WID_W'(BASE_BITS) + WID_W'(code);

    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        localparam int DIST = OUT_W - b;
        if (b <= TOP_POS && b >= LOW_POS) begin : g_pos
            assign addend[b] = (code == CODE_W'(TOP_POS - b));
        end else begin : g_none
            assign addend[b] = 1'b0;
        end
        assign mask[b] = (WID_W'(DIST) <= width);
    end
endmodule

// File: rtl/round_adder.sv
module round_adder #(
    parameter int OUT_W = round_pkg::OUT_W
) (
    input  logic [OUT_W-1:0] operand,
    input  logic [OUT_W-1:0] addend,
    output logic [OUT_W-1:0] result
);
    // modulo 2^OUT_W: the carry out of the top bit is discarded
    assign result = operand + addend;
endmodule

// File: rtl/round_stage.sv
module round_stage
    import round_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [OUT_W-1:0]     in_sum,
    input  logic [CODE_W-1:0]    in_code,
    input  logic                 in_even_sym,
    input  logic                 in_data_uns,
    input  logic                 in_coef_uns,
    output logic                 out_valid,
    output logic [OUT_W-1:0]     out_word,
    output logic [OUT_W-1:0]     out_mask,
    output logic [WID_W-1:0]     out_width,
    output logic                 out_signed
);
    word_t             addend, mask_d, rounded;
    logic [WID_W-1:0]  width_d;
    rnd_out_t          q;

    round_decode u_dec (
        .code   (in_code),
        .addend (addend),
        .mask   (mask_d),
        .width  (width_d)
    );

    round_adder u_add (
        .operand (in_sum),
        .addend  (addend),
        .result  (rounded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid;
            if (in_valid) begin
                q.word      <= rounded;
                q.mask      <= mask_d;
                q.width     <= width_d;
                q.is_signed <= result_signed(in_even_sym, in_data_uns, in_coef_uns);
            end
        end
    end

    assign out_valid  = q.valid;
    assign out_word   = q.word;
    assign out_mask   = q.mask;
    assign out_width  = q.width;
    assign out_signed = q.is_signed;
endmodule

// File: rtl/round_stage_chk.sv
module round_stage_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [27:0] in_sum,
    input logic [3:0]  in_code,
    input logic        in_even_sym,
    input logic        in_data_uns,
    input logic        in_coef_uns,
    input logic        out_valid,
    input logic [27:0] out_word,
    input logic [27:0] out_mask,
    input logic [4:0]  out_width,
    input logic        out_signed
);
    logic        chk_res;
    logic [27:0] chk_add;
    assign chk_res = (in_code >= 4'd12);
    assign chk_add = chk_res ? 28'd0 : (28'd1 << (5'd19 - {1'b0, in_code}));

    assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word) && $stable(out_width) && $stable(out_signed));
    assert_round_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !chk_res) |=> out_word == $past(in_sum + chk_add));
    assert_width_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !chk_res) |=> out_width == $past(5'd8 + {1'b0, in_code}));
    assert_mask_ones_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_mask) == int'(out_width));
    assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && chk_res) |=> out_word == $past(in_sum) && out_width == 5'd28);
    assert_format_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_signed == $past(!(in_even_sym && in_data_uns && in_coef_uns)));
endmodule

bind round_stage round_stage_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sum(in_sum), .in_code(in_code),
    .in_even_sym(in_even_sym), .in_data_uns(in_data_uns), .in_coef_uns(in_coef_uns),
    .out_valid(out_valid), .out_word(out_word), .out_mask(out_mask),
    .out_width(out_width), .out_signed(out_signed)
);

// File: tb/sim_round_stage.sv
`timescale 1ns/1ps
module sim_round_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [27:0] in_sum = '0;
    logic [3:0]  in_code = '0;
    logic        in_even_sym = 1'b0, in_data_uns = 1'b0, in_coef_uns = 1'b0;
    logic        out_valid;
    logic [27:0] out_word, out_mask;
    logic [4:0]  out_width;
    logic        out_signed;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    round_stage u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] exp_word(input logic [27:0] s, input logic [3:0] c);
        if (c > 4'd11) return s;
        return s + (28'd1 << (19 - int'(c)));
    endfunction

    function automatic logic [4:0] exp_width(input logic [3:0] c);
        return (c > 4'd11) ? 5'd28 : 5'd8 + 5'(c);
    endfunction

    function automatic logic [27:0] exp_mask(input logic [3:0] c);
        logic [27:0] m = '0;
        for (int b = 0; b < 28; b++) if (b >= 28 - int'(exp_width(c))) m[b] = 1'b1;
        return m;
    endfunction

    // drive one sample at a falling edge; result appears after the next rising edge
    task automatic drive(input logic [27:0] s, input logic [3:0] c, input logic es,
                         input logic du, input logic cu);
        in_valid = 1'b1; in_sum = s; in_code = c;
        in_even_sym = es; in_data_uns = du; in_coef_uns = cu;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 word", 32'(out_word), 0);
        chk("R1 mask", 32'(out_mask), 0);
        chk("R1 width", 32'(out_width), 0);
        chk("R1 signed", 32'(out_signed), 0);
    endtask

    task automatic t_all_codes();
        for (int c = 0; c < 16; c++) begin
            logic [27:0] s = 28'h0123456 ^ 28'(c * 28'h0011111);
            drive(s, 4'(c), 1'b0, 1'b0, 1'b0);
            chk("R2 valid", 32'(out_valid), 1);
            chk(c < 12 ? "R3 word" : "R5 word", 32'(out_word), 32'(exp_word(s, 4'(c))));
            chk(c < 12 ? "R4 width" : "R5 width", 32'(out_width), 32'(exp_width(4'(c))));
            chk(c < 12 ? "R4 mask" : "R5 mask", 32'(out_mask), 32'(exp_mask(4'(c))));
            idle();
        end
    endtask

    task automatic t_ten_msbs();
        drive(28'h0000000, 4'd2, 1'b0, 1'b0, 1'b0);
        chk("R9 word", 32'(out_word), 32'h0020000);
        chk("R9 width", 32'(out_width), 10);
        chk("R9 mask", 32'(out_mask), 32'hFFC0000);
        idle();
    endtask

    task automatic t_wrap();
        drive(28'hFFFFFFF, 4'd0, 1'b0, 1'b0, 1'b0);
        chk("R6 wrap", 32'(out_word), 32'h007FFFF);
        drive(28'hFFFFFFF, 4'd11, 1'b0, 1'b0, 1'b0);
        chk("R6 wrap low", 32'(out_word), 32'h00000FF);
        idle();
    endtask

    task automatic t_format();
        for (int f = 0; f < 8; f++) begin
            drive(28'h0001000, 4'd5, f[2], f[1], f[0]);
            chk("R7 signed", 32'(out_signed), (f == 7) ? 0 : 1);
            idle();
        end
    endtask

    task automatic t_hold();
        drive(28'h0A00000, 4'd3, 1'b1, 1'b1, 1'b1);
        in_valid = 1'b0; in_sum = 28'h5555555; in_code = 4'd9;
        in_even_sym = 1'b0;
        @(negedge clk);
        chk("R2 valid low", 32'(out_valid), 0);
        chk("R2 hold word", 32'(out_word), 32'(exp_word(28'h0A00000, 4'd3)));
        chk("R2 hold width", 32'(out_width), 11);
        chk("R2 hold signed", 32'(out_signed), 0);
    endtask

    task automatic t_back_to_back();
        drive(28'h0100000, 4'd0, 1'b1, 1'b1, 1'b1);
        chk("R8 first word", 32'(out_word), 32'h0180000);
        chk("R8 first signed", 32'(out_signed), 0);
        drive(28'h0100000, 4'd11, 1'b0, 1'b1, 1'b1);
        chk("R8 second word", 32'(out_word), 32'h0100100);
        chk("R8 second width", 32'(out_width), 19);
        chk("R8 second signed", 32'(out_signed), 1);
        drive(28'h0100000, 4'd14, 1'b1, 1'b1, 1'b1);
        chk("R8 third word", 32'(out_word), 32'h0100000);
        chk("R8 third width", 32'(out_width), 28);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_codes();
        t_ten_msbs();
        t_wrap();
        t_format();
        t_hold();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule